// File: doc/BRIEF.md
# Panel Line and Frame Timing Regenerator

This block rebuilds the line and frame timing of a flat panel from an incoming pixel stream. The stream has a frame sync, a data-enable and 24-bit colour. One pixel arrives per clock. The block keeps a pixel counter and a line counter and works out which pixels belong to the visible area. It then sends the colour data one clock later, together with a regenerated output enable. Downstream control-signal generators use the pixel and line counts, which leave the block on the same clock edge as the data.

Each axis has its own mode bit. In fixed mode the active area sits at a programmable backporch offset, counted from the rising edge of the frame sync. In enable-derived mode the active area follows the incoming data-enable. Lines past the last active line can optionally be filled with all-ones (white) data until the next frame sync arrives.

Top module: `panel_retimer`

## Requirements
- R1: While reset is asserted, `rgb_out`, `de_out`, `pix_cnt` and `line_cnt` are all zero.
- R2: Every output is registered. The outputs after a clock edge reflect the inputs that were sampled at that edge.
- R3: With `cfg_fix_h`=1, the pixel count is 0 in the cycle of a `vsync_in` rising edge. It then counts 0 to H_TOTAL-1 and wraps, and each wrap starts a new line.
- R4: With `cfg_fix_h`=0, the pixel count is 0 in the cycle of a `de_in` rising edge and then increments by one per clock. Each `de_in` rising edge starts a new line.
- R5: The line count is 0 in the cycle of a `vsync_in` rising edge and increments by one at each line start.
- R6: With `cfg_fix_h`=1, a pixel is horizontally active when `cfg_hbp` <= pixel count < `cfg_hbp`+H_ACT. `de_in` has no effect on the horizontal position.
- R7: With `cfg_fix_v`=1, a line is vertically active when `cfg_vbp` <= line count < `cfg_vbp`+V_ACT.
- R8: With `cfg_fix_v`=0, the vertical origin is the line of the first `de_in`-high cycle after a `vsync_in` rising edge. The V_ACT lines starting there are active. Before that cycle no line is active.
- R9: With `cfg_fix_h`=0, a pixel is horizontally active exactly when `de_in` is high.
- R10: `de_out` is high exactly when the pixel is both horizontally and vertically active.
- R11: With `cfg_white_en`=1, lines after the vertical active area output `rgb_out`=24'hFFFFFF with `de_out` low. This lasts until the next `vsync_in` rising edge.
- R12: With `cfg_white_en`=0, or on any line not past the active area, `rgb_out` equals the sampled `rgb_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Frame sync; the rising edge starts a frame |
| de_in | input | 1 | Input data enable |
| rgb_in | input | 24 | Input pixel colour |
| cfg_fix_h | input | 1 | 1: fixed horizontal placement; 0: enable-derived |
| cfg_fix_v | input | 1 | 1: fixed vertical placement; 0: enable-derived |
| cfg_white_en | input | 1 | Enables white fill after the active lines |
| cfg_hbp | input | 11 | Horizontal backporch in pixels |
| cfg_vbp | input | 11 | Vertical backporch in lines |
| rgb_out | output | 24 | Retimed colour, or white fill |
| de_out | output | 1 | Regenerated output enable |
| pix_cnt | output | 11 | Pixel count of the output pixel |
| line_cnt | output | 11 | Line count of the output pixel |

## Verification
Every result is due exactly one clock after the inputs that cause it. This holds for the counts, the enable and the colour, because each path has a single register. The bench therefore drives a stimulus on the falling edge, waits for the next rising edge and samples shortly after it, before the next drive. For every driven cycle, the expected pixel, line, enable and colour are computed from the cycle's position relative to the frame sync and the first data-enable. The bench checks all of them, including the cycles where white fill begins and where a new frame sync ends it.

// File: rtl/panel_retimer_pkg.sv
package panel_retimer_pkg;
  // Vertical position of the current line relative to the active area.
  typedef struct packed {
    logic act;   // inside the active lines
    logic past;  // after the last active line
  } vzone_t;
endpackage

// File: rtl/panel_retimer_hcnt.sv
module panel_retimer_hcnt #(
  parameter int CW      = 11,
  parameter int H_TOTAL = 1200,
  parameter int H_ACT   = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_h,
  input  logic          vs_rise,
  input  logic          de_rise,
  input  logic          de_in,
  input  logic [CW-1:0] hbp,
  output logic [CW-1:0] pix_d,
  output logic          line_start,
  output logic          h_act
);
  localparam logic [CW-1:0] H_LAST = CW'(H_TOTAL - 1);
  localparam logic [CW-1:0] C_MAX  = {CW{1'b1}};
  localparam logic [CW:0]   H_SPAN = (CW+1)'(H_ACT);

  logic [CW-1:0] pix_q;
  logic [CW:0]   pix_e;
  logic [CW:0]   hbp_e;

  always_comb begin
    if (fix_h) line_start = !vs_rise && (pix_q >= H_LAST);
    else       line_start = de_rise;

    if (fix_h && vs_rise)  pix_d = '0;
    else if (line_start)   pix_d = '0;
    else if (pix_q != C_MAX) pix_d = pix_q + CW'(1);
    else                   pix_d = pix_q;

    pix_e = {1'b0, pix_d};
    hbp_e = {1'b0, hbp};
    if (fix_h) h_act = (pix_e >= hbp_e) && (pix_e < hbp_e + H_SPAN);
    else       h_act = de_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_d;
  end

  // R3: in fixed mode the counter wraps to zero after the last pixel of a line
  p_fixed_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_h && !vs_rise && pix_q == H_LAST) |=> (pix_q == '0));

  // R4: in enable-derived mode a data-enable rising edge restarts the count
  p_de_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_h && de_rise) |=> (pix_q == '0));
endmodule

// File: rtl/panel_retimer_vcnt.sv
module panel_retimer_vcnt
  import panel_retimer_pkg::*;
#(
  parameter int CW    = 11,
  parameter int V_ACT = 768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_v,
  input  logic          vs_rise,
  input  logic          line_start,
  input  logic          de_in,
  input  logic [CW-1:0] vbp,
  output logic [CW-1:0] line_d,
  output vzone_t        zone
);
  localparam logic [CW-1:0] C_MAX  = {CW{1'b1}};
  localparam logic [CW:0]   V_SPAN = (CW+1)'(V_ACT);

  logic [CW-1:0] line_q, orig_q, orig_d, base, idx;
  logic          seen_q, seen_d, first_de, v_in, line_en;

  always_comb begin
    line_en = vs_rise || line_start;
    if (vs_rise)                          line_d = '0;
    else if (line_start && line_q != C_MAX) line_d = line_q + CW'(1);
    else                                  line_d = line_q;

    first_de = !vs_rise && de_in && !seen_q;
    seen_d   = vs_rise ? 1'b0 : (seen_q || de_in);
    orig_d   = first_de ? line_d : orig_q;

    base = fix_v ? vbp : orig_d;
    v_in = fix_v ? (line_d >= vbp) : seen_d;
    idx  = line_d - base;
    zone.act  = v_in && ({1'b0, idx} <  V_SPAN);
    zone.past = v_in && ({1'b0, idx} >= V_SPAN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      orig_q <= '0;
      seen_q <= 1'b0;
    end else begin
      if (line_en)  line_q <= line_d;
      if (first_de) orig_q <= orig_d;
      seen_q <= seen_d;
    end
  end

  // R5: a frame sync edge clears the line count
  p_line_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vs_rise |=> (line_q == '0));

  // R5: each line start advances the line count by one
  p_line_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_rise && line_start && line_q != C_MAX) |=> (line_q == $past(line_q) + CW'(1)));
endmodule

// File: rtl/panel_retimer_out.sv
module panel_retimer_out
  import panel_retimer_pkg::*;
#(
  parameter int CW    = 11,
  parameter int RGB_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_act,
  input  vzone_t           zone,
  input  logic             white_en,
  input  logic [RGB_W-1:0] rgb_in,
  input  logic [CW-1:0]    pix_d,
  input  logic [CW-1:0]    line_d,
  output logic [RGB_W-1:0] rgb_out,
  output logic             de_out,
  output logic [CW-1:0]    pix_cnt,
  output logic [CW-1:0]    line_cnt
);
  logic             white_sel;
  logic [RGB_W-1:0] rgb_d;
  logic             de_d;

  always_comb begin
    white_sel = white_en && zone.past;
    rgb_d     = white_sel ? {RGB_W{1'b1}} : rgb_in;
    de_d      = h_act && zone.act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_out  <= '0;
      de_out   <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
    end else begin
      rgb_out  <= rgb_d;
      de_out   <= de_d;
      pix_cnt  <= pix_d;
      line_cnt <= line_d;
    end
  end

  // R12: without white fill the colour passes unchanged, one clock late
  p_rgb_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !white_en |=> (rgb_out == $past(rgb_in)));

  // R11: white-filled lines never carry an output enable
  p_white_no_de_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (white_en && zone.past) |=> !de_out);
endmodule

// File: rtl/panel_retimer.sv
module panel_retimer
  import panel_retimer_pkg::*;
#(
  parameter int CW      = 11,
  parameter int RGB_W   = 24,
  parameter int H_TOTAL = 1200,
  parameter int H_ACT   = 1024,
  parameter int V_ACT   = 768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic             de_in,
  input  logic [RGB_W-1:0] rgb_in,
  input  logic             cfg_fix_h,
  input  logic             cfg_fix_v,
  input  logic             cfg_white_en,
  input  logic [CW-1:0]    cfg_hbp,
  input  logic [CW-1:0]    cfg_vbp,
  output logic [RGB_W-1:0] rgb_out,
  output logic             de_out,
  output logic [CW-1:0]    pix_cnt,
  output logic [CW-1:0]    line_cnt
);
  logic          vs_q, de_q, vs_rise, de_rise;
  logic [CW-1:0] pix_d, line_d;
  logic          line_start, h_act;
  vzone_t        zone;

  always_comb begin
    vs_rise = vsync_in && !vs_q;
    de_rise = de_in && !de_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0;
      de_q <= 1'b0;
    end else begin
      vs_q <= vsync_in;
      de_q <= de_in;
    end
  end

  panel_retimer_hcnt #(.CW(CW), .H_TOTAL(H_TOTAL), .H_ACT(H_ACT)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .fix_h(cfg_fix_h), .vs_rise(vs_rise),
    .de_rise(de_rise), .de_in(de_in), .hbp(cfg_hbp),
    .pix_d(pix_d), .line_start(line_start), .h_act(h_act)
  );

  panel_retimer_vcnt #(.CW(CW), .V_ACT(V_ACT)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .fix_v(cfg_fix_v), .vs_rise(vs_rise),
    .line_start(line_start), .de_in(de_in), .vbp(cfg_vbp),
    .line_d(line_d), .zone(zone)
  );

  panel_retimer_out #(.CW(CW), .RGB_W(RGB_W)) u_out (
    .clk(clk), .rst_n(rst_n), .h_act(h_act), .zone(zone),
    .white_en(cfg_white_en), .rgb_in(rgb_in), .pix_d(pix_d), .line_d(line_d),
    .rgb_out(rgb_out), .de_out(de_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  // R8: the frame sync edge cycle without enable has no active line yet
  p_vs_blanks_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fix_v && vs_rise && !de_in) |=> !de_out);

  // R9: in enable-derived horizontal mode a low enable gives a low output enable
  p_de_follows_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fix_h && !de_in) |=> !de_out);
endmodule

// File: tb/panel_retimer_bench.sv
`timescale 1ns/1ps
module panel_retimer_bench;
  localparam int CW = 11;
  localparam int HT = 16;
  localparam int HA = 8;
  localparam int VA = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vsync_in = 1'b0, de_in = 1'b0;
  logic [23:0]   rgb_in = '0;
  logic          cfg_fix_h = 1'b1, cfg_fix_v = 1'b1, cfg_white_en = 1'b0;
  logic [CW-1:0] cfg_hbp = '0, cfg_vbp = '0;
  logic [23:0]   rgb_out;
  logic          de_out;
  logic [CW-1:0] pix_cnt, line_cnt;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  panel_retimer #(.CW(CW), .RGB_W(24), .H_TOTAL(HT), .H_ACT(HA), .V_ACT(VA)) u_panel_retimer (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .de_in(de_in), .rgb_in(rgb_in),
    .cfg_fix_h(cfg_fix_h), .cfg_fix_v(cfg_fix_v), .cfg_white_en(cfg_white_en),
    .cfg_hbp(cfg_hbp), .cfg_vbp(cfg_vbp),
    .rgb_out(rgb_out), .de_out(de_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the next rising edge.
  task automatic step(input logic vs, input logic de, input logic [23:0] d);
    @(negedge clk);
    vsync_in = vs; de_in = de; rgb_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 rgb", {8'h0, rgb_out}, 32'h0);
    chk("R1 de", {31'h0, de_out}, 32'h0);
    chk("R1 pix", {21'h0, pix_cnt}, 32'h0);
    chk("R1 line", {21'h0, line_cnt}, 32'h0);
  endtask

  // Fixed placement on both axes: hbp=3, vbp=2; de_in toggles and is ignored.
  task automatic t_fixed(input bit w);
    cfg_fix_h = 1'b1; cfg_fix_v = 1'b1; cfg_hbp = 11'd3; cfg_vbp = 11'd2; cfg_white_en = w;
    step(1'b0, 1'b0, 24'h0);
    for (int t = 0; t < 8*HT; t++) begin
      logic [23:0] d;
      int px, ln;
      bit ex_de, past;
      d  = 24'h5A0000 | 24'(t);
      step(t == 0, t[2], d);
      px = t % HT; ln = t / HT;
      ex_de = (px >= 3 && px < 3+HA) && (ln >= 2 && ln < 2+VA);
      past  = ln >= 2+VA;
      chk("R3 pix", {21'h0, pix_cnt}, 32'(px));
      chk("R5 line", {21'h0, line_cnt}, 32'(ln));
      chk("R6 R7 R10 de", {31'h0, de_out}, {31'h0, ex_de});
      if (w && past) chk("R11 white", {8'h0, rgb_out}, 32'hFFFFFF);
      else           chk("R2 R12 rgb", {8'h0, rgb_out}, {8'h0, d});
    end
    // frame sync edge in the middle of a line restarts both counts
    step(1'b0, 1'b0, 24'h1);
    step(1'b1, 1'b0, 24'h2);
    chk("R3 pix restart", {21'h0, pix_cnt}, 32'h0);
    chk("R5 line restart", {21'h0, line_cnt}, 32'h0);
    chk("R11 white stops", {8'h0, rgb_out}, 32'h2);
    step(1'b0, 1'b0, 24'h3);
    chk("R3 pix next", {21'h0, pix_cnt}, 32'h1);
  endtask

  // Enable-derived on both axes: 6 lines of 3 blank + 8 enabled cycles.
  task automatic t_enable(input bit w);
    cfg_fix_h = 1'b0; cfg_fix_v = 1'b0; cfg_white_en = w;
    step(1'b0, 1'b0, 24'h0);
    step(1'b1, 1'b0, 24'h123456);
    chk("R5 line at vsync", {21'h0, line_cnt}, 32'h0);
    chk("R8 no de before origin", {31'h0, de_out}, 32'h0);
    chk("R12 rgb before origin", {8'h0, rgb_out}, 32'h123456);
    for (int L = 0; L < 6; L++) begin
      for (int b = 0; b < 3; b++) begin
        logic [23:0] d;
        d = 24'hB00000 | 24'(L*16 + b);
        step(1'b0, 1'b0, d);
        chk("R5 line blank", {21'h0, line_cnt}, 32'(L));
        if (L > 0) chk("R4 pix blank", {21'h0, pix_cnt}, 32'(HA + b));
        chk("R9 de blank", {31'h0, de_out}, 32'h0);
        if (w && L >= VA+1) chk("R11 white blank", {8'h0, rgb_out}, 32'hFFFFFF);
        else                chk("R12 rgb blank", {8'h0, rgb_out}, {8'h0, d});
      end
      for (int k = 0; k < HA; k++) begin
        logic [23:0] d;
        d = 24'hC00000 | 24'(L*16 + k);
        step(1'b0, 1'b1, d);
        chk("R4 pix", {21'h0, pix_cnt}, 32'(k));
        chk("R5 line", {21'h0, line_cnt}, 32'(L+1));
        chk("R8 R9 R10 de", {31'h0, de_out}, {31'h0, (L < VA)});
        if (w && L >= VA) chk("R11 white", {8'h0, rgb_out}, 32'hFFFFFF);
        else              chk("R12 rgb", {8'h0, rgb_out}, {8'h0, d});
      end
    end
    step(1'b1, 1'b0, 24'h654321);
    chk("R5 line cleared", {21'h0, line_cnt}, 32'h0);
    chk("R11 white ends at vsync", {8'h0, rgb_out}, 32'h654321);
    step(1'b0, 1'b0, 24'h0);
  endtask

  // Fixed horizontal, enable-derived vertical: origin at first enable (line 2).
  task automatic t_mixed;
    cfg_fix_h = 1'b1; cfg_fix_v = 1'b0; cfg_hbp = 11'd3; cfg_white_en = 1'b1;
    step(1'b0, 1'b0, 24'h0);
    for (int t = 0; t < 8*HT; t++) begin
      logic [23:0] d;
      int px, ln;
      bit seen, ex_de;
      d  = 24'h330000 | 24'(t);
      px = t % HT; ln = t / HT;
      seen  = t >= 2*HT + 5;
      step(t == 0, (t >= 2*HT+5) && (t < 2*HT+13), d);
      ex_de = seen && (ln >= 2 && ln < 2+VA) && (px >= 3 && px < 3+HA);
      chk("R3 pix mixed", {21'h0, pix_cnt}, 32'(px));
      chk("R6 R8 R10 de mixed", {31'h0, de_out}, {31'h0, ex_de});
      if (seen && ln >= 2+VA) chk("R11 white mixed", {8'h0, rgb_out}, 32'hFFFFFF);
      else                    chk("R12 rgb mixed", {8'h0, rgb_out}, {8'h0, d});
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fixed(1'b0);
    t_fixed(1'b1);
    t_enable(1'b0);
    t_enable(1'b1);
    t_mixed();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule